// File: doc/BRIEF.md
# Clustered Loop Instruction Buffer Controller

This block stands between an L1 instruction memory and a datapath whose functional units are grouped into a small number of instruction clusters. The branch slot counts as one more cluster. A loop-start command gives a start address and an offset; the offset is the loop-relative address of the last instruction of the body. The block then prefetches the whole body from L1, one word per cycle, while it holds `fill_busy`. Each word is split per cluster. A cluster keeps only its real operations, in its own small partition. A shared usage table records, for every loop-relative address, whether each cluster is active there and the compacted index of its operation.

Once the fill is done, fetches that fall inside the loop range are served from the partitions one cycle later. Only the partitions whose usage bit is set are read. The other clusters receive a NOP. Jumps inside the range keep the block serving, so if/else paths and the backward branch to the loop head both stay in the buffer. A fetch outside the range ends buffer operation, and the core returns to L1. If the body is longer than the table, the command is ignored. If a cluster runs out of partition space during the fill, the fill is abandoned.

Top module: `lbuf_ctrl`

## Requirements
- R1: A loop-start command with offset below TBL_DEPTH is accepted when the block is idle or executing. From the next cycle, `fill_busy` is 1 until the fill ends, and `dp_valid` stays 0 throughout. A loop-start command that arrives during a fill is ignored.
- R2: A loop-start command with offset of TBL_DEPTH or more is ignored. No fill starts, and a fetch issued in the same cycle during execution is still served.
- R3: During a fill, `l1_rd` is asserted once per cycle with `l1_addr` = start + k, for k = 0 up to the offset in order. `l1_rdata` is taken one cycle after each read. Execution starts the cycle after the last word arrives, so an accepted fill lasts offset + 2 cycles.
- R4: Cluster c occupies bits [c*OP_W +: OP_W] of an instruction word, and the value 0 is a NOP. Only non-zero operations take partition space. A body in which a cluster has exactly PART_DEPTH operations fits.
- R5: While executing, a fetch with `fetch_en` = 1 and start <= `fetch_pc` <= start + offset gives `dp_valid` = 1 in the next cycle. `dp_ops` then equals the L1 word at that address, with NOP fields restored as 0.
- R6: With each served word, bit c of `part_act` is 1 exactly when cluster c has a non-zero operation at that address, and only those partitions are read. When no word is served, `part_act` is 0.
- R7: While executing, a fetch outside the range (below the start or above the end) terminates buffer operation. `dp_valid` is 0 in the next cycle, and later fetches are not served until a new loop start.
- R8: If any cluster would need more than PART_DEPTH entries, the fill is abandoned one cycle after the offending word arrives. The block goes idle and serves nothing.
- R9: The branch slot is the highest cluster and is handled like the others. Jumps within the range, both forward over a block and backward to the start, are served without extra cycles.
- R10: If a loop-start command and a fetch arrive in the same cycle during execution, the loop start takes effect. The fetch is not served, and the new fill begins.
- R11: In reset, `fill_busy`, `dp_valid`, `l1_rd` and `part_act` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lbon_valid | input | 1 | Loop-start command strobe |
| lbon_start | input | AW | Loop start address |
| lbon_ofs | input | AW | Loop-relative address of the last body word |
| fetch_en | input | 1 | Core fetch request |
| fetch_pc | input | AW | Core fetch address |
| l1_rd | output | 1 | L1 read strobe during fill |
| l1_addr | output | AW | L1 read address |
| l1_rdata | input | N_CL*OP_W | L1 word, valid the cycle after `l1_rd` |
| fill_busy | output | 1 | Fill in progress; the core must stall |
| dp_valid | output | 1 | A buffered word is delivered this cycle |
| dp_ops | output | N_CL*OP_W | Per-cluster operations, 0 for NOP |
| part_act | output | N_CL | Partitions read for the delivered word |

## Verification
During execution, a loop-start command and a fetch can land in the same cycle. Termination and acceptance of a new loop can also coincide, as can an oversize command and a normal fetch. The bench drives each pairing while the block is serving. A behavioural model decides the outcome every clock: the accepted command wins, while an oversize command loses to the fetch. The bench then checks that `dp_valid`, `fill_busy` and the L1 read stream follow that outcome from the next cycle on.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EXEC = 2'd2
  } lbc_state_e;
endpackage

// File: rtl/lbc_seq.sv
module lbc_seq
  import lbc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int TBL_DEPTH = 16,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lbon_valid,
  input  logic [AW-1:0]     lbon_start,
  input  logic [AW-1:0]     lbon_ofs,
  input  logic              fetch_en,
  input  logic [AW-1:0]     fetch_pc,
  input  logic              ovf_any,
  output lbc_state_e        state,
  output logic              l1_rd,
  output logic [AW-1:0]     l1_addr,
  output logic              fill_wr,
  output logic [TBL_AW-1:0] wr_rel,
  output logic              fill_clr,
  output logic              exec_hit,
  output logic [TBL_AW-1:0] exec_rel
);
  logic [AW-1:0]     start_q;
  logic [TBL_AW-1:0] ofs_q, rd_ptr_q, wr_rel_q;
  logic              issuing_q, wr_vld_q;
  logic [AW-1:0]     rel_fetch;
  logic              in_range, accept;

  assign accept    = lbon_valid && (lbon_ofs < AW'(TBL_DEPTH)) && (state != ST_FILL);
  assign rel_fetch = fetch_pc - start_q;
  assign in_range  = rel_fetch <= AW'(ofs_q);
  assign exec_hit  = (state == ST_EXEC) && fetch_en && in_range && !accept;
  assign exec_rel  = rel_fetch[TBL_AW-1:0];
  assign l1_rd     = (state == ST_FILL) && issuing_q;
  assign l1_addr   = start_q + AW'(rd_ptr_q);
  assign fill_wr   = wr_vld_q && (state == ST_FILL);
  assign wr_rel    = wr_rel_q;
  assign fill_clr  = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      start_q   <= '0;
      ofs_q     <= '0;
      rd_ptr_q  <= '0;
      wr_rel_q  <= '0;
      issuing_q <= 1'b0;
      wr_vld_q  <= 1'b0;
    end else begin
      wr_vld_q <= l1_rd;
      wr_rel_q <= rd_ptr_q;
      case (state)
        ST_FILL: begin
          if (l1_rd) begin
            rd_ptr_q <= rd_ptr_q + 1'b1;
            if (rd_ptr_q == ofs_q) issuing_q <= 1'b0;
          end
          if (wr_vld_q) begin
            if (ovf_any) begin
              state     <= ST_IDLE;
              issuing_q <= 1'b0;
            end else if (wr_rel_q == ofs_q) begin
              state <= ST_EXEC;
            end
          end
        end
        default: begin
          if (accept) begin
            state     <= ST_FILL;
            start_q   <= lbon_start;
            ofs_q     <= lbon_ofs[TBL_AW-1:0];
            rd_ptr_q  <= '0;
            issuing_q <= 1'b1;
          end else if (state == ST_EXEC && fetch_en && !in_range) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  p_fill_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
    (l1_rd && $past(l1_rd)) |-> (l1_addr == $past(l1_addr) + AW'(1)));

  p_oversize_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (lbon_valid && lbon_ofs >= AW'(TBL_DEPTH) && state == ST_IDLE) |=> (state == ST_IDLE));

  p_exit_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && fetch_en && !in_range && !accept) |=> (state == ST_IDLE));
endmodule

// File: rtl/lbc_usage_table.sv
module lbc_usage_table #(
  parameter int TBL_DEPTH = 16,
  parameter int ENT_W     = 16,
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TBL_AW-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [TBL_AW-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  logic [ENT_W-1:0] mem [TBL_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lbc_partition.sv
module lbc_partition #(
  parameter int OP_W       = 8,
  parameter int PART_DEPTH = 8,
  localparam int IDX_W     = $clog2(PART_DEPTH),
  localparam int CNT_W     = $clog2(PART_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OP_W-1:0]  op_in,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             use_out,
  output logic [IDX_W-1:0] idx_out,
  output logic             ovf,
  output logic [OP_W-1:0]  rd_q
);
  logic [OP_W-1:0]  mem [PART_DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             full, store;

  assign use_out = op_in != '0;
  assign full    = cnt_q == CNT_W'(PART_DEPTH);
  assign store   = wr_en && use_out && !full;
  assign ovf     = wr_en && use_out && full;
  assign idx_out = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (store)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (store) mem[cnt_q[IDX_W-1:0]] <= op_in;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_idx];
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(PART_DEPTH));

  p_no_read_in_fill_r6: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !wr_en);
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbc_pkg::*;
#(
  parameter int N_CL       = 4,
  parameter int OP_W       = 8,
  parameter int AW         = 16,
  parameter int TBL_DEPTH  = 16,
  parameter int PART_DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lbon_valid,
  input  logic [AW-1:0]        lbon_start,
  input  logic [AW-1:0]        lbon_ofs,
  input  logic                 fetch_en,
  input  logic [AW-1:0]        fetch_pc,
  output logic                 l1_rd,
  output logic [AW-1:0]        l1_addr,
  input  logic [N_CL*OP_W-1:0] l1_rdata,
  output logic                 fill_busy,
  output logic                 dp_valid,
  output logic [N_CL*OP_W-1:0] dp_ops,
  output logic [N_CL-1:0]      part_act
);
  localparam int TBL_AW = $clog2(TBL_DEPTH);
  localparam int IDX_W  = $clog2(PART_DEPTH);
  localparam int SLOT_W = IDX_W + 1;
  localparam int ENT_W  = N_CL * SLOT_W;

  lbc_state_e        state;
  logic              fill_wr, fill_clr, exec_hit, ovf_any;
  logic [TBL_AW-1:0] wr_rel, exec_rel;
  logic [ENT_W-1:0]  ent_wr, ent_rd;
  logic [N_CL-1:0]   ovf, rd_en;
  logic              dp_valid_q;
  logic [N_CL-1:0]   act_q;

  assign ovf_any = |ovf;

  lbc_seq #(.AW(AW), .TBL_DEPTH(TBL_DEPTH)) u_seq (
    .clk(clk), .rst(rst), .lbon_valid(lbon_valid), .lbon_start(lbon_start),
    .lbon_ofs(lbon_ofs), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
    .ovf_any(ovf_any), .state(state), .l1_rd(l1_rd), .l1_addr(l1_addr),
    .fill_wr(fill_wr), .wr_rel(wr_rel), .fill_clr(fill_clr),
    .exec_hit(exec_hit), .exec_rel(exec_rel)
  );

  lbc_usage_table #(.TBL_DEPTH(TBL_DEPTH), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .we(fill_wr), .waddr(wr_rel), .wdata(ent_wr),
    .raddr(exec_rel), .rdata(ent_rd)
  );

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    logic             use_w;
    logic [IDX_W-1:0] idx_w;
    logic [OP_W-1:0]  q;

    assign rd_en[c] = exec_hit && ent_rd[c*SLOT_W + IDX_W];

    lbc_partition #(.OP_W(OP_W), .PART_DEPTH(PART_DEPTH)) u_part (
      .clk(clk), .rst(rst), .clr(fill_clr), .wr_en(fill_wr),
      .op_in(l1_rdata[c*OP_W +: OP_W]), .rd_en(rd_en[c]),
      .rd_idx(ent_rd[c*SLOT_W +: IDX_W]), .use_out(use_w), .idx_out(idx_w),
      .ovf(ovf[c]), .rd_q(q)
    );

    assign ent_wr[c*SLOT_W +: SLOT_W] = {use_w, idx_w};
    assign dp_ops[c*OP_W +: OP_W]     = act_q[c] ? q : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid_q <= 1'b0;
      act_q      <= '0;
    end else begin
      dp_valid_q <= exec_hit;
      act_q      <= rd_en;
    end
  end

  assign dp_valid  = dp_valid_q;
  assign part_act  = act_q;
  assign fill_busy = state == ST_FILL;

  p_fill_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> !dp_valid);

  p_serve_after_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    dp_valid |-> $past(fetch_en));

  p_act_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (part_act != '0) |-> dp_valid);
endmodule

// File: tb/lbuf_ctrl_tb.sv
module lbuf_ctrl_tb;
  localparam int N_CL = 4, OP_W = 8, AW = 16, TD = 16, PD = 8;
  localparam time CLK_P = 8ns;

  logic clk = 0, rst = 1;
  logic lbon_valid = 0, fetch_en = 0;
  logic [AW-1:0] lbon_start = 0, lbon_ofs = 0, fetch_pc = 0;
  logic l1_rd, fill_busy, dp_valid;
  logic [AW-1:0] l1_addr;
  logic [N_CL*OP_W-1:0] l1_rdata, dp_ops;
  logic [N_CL-1:0] part_act;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lbuf_ctrl #(.N_CL(N_CL), .OP_W(OP_W), .AW(AW), .TBL_DEPTH(TD), .PART_DEPTH(PD)) u_dut (
    .clk(clk), .rst(rst), .lbon_valid(lbon_valid), .lbon_start(lbon_start),
    .lbon_ofs(lbon_ofs), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
    .l1_rd(l1_rd), .l1_addr(l1_addr), .l1_rdata(l1_rdata),
    .fill_busy(fill_busy), .dp_valid(dp_valid), .dp_ops(dp_ops), .part_act(part_act)
  );

  function automatic logic [OP_W-1:0] op_at(int a, int c);
    int v;
    if ((a + c) % 3 == 0) return '0;
    v = (a * 7 + c * 13 + 3) & 255;
    if (v == 0) v = 1;
    return OP_W'(v);
  endfunction

  function automatic logic [N_CL*OP_W-1:0] word_at(int a);
    logic [N_CL*OP_W-1:0] w;
    for (int c = 0; c < N_CL; c++) w[c*OP_W +: OP_W] = op_at(a, c);
    return w;
  endfunction

  function automatic logic [N_CL-1:0] act_at(int a);
    logic [N_CL-1:0] m;
    for (int c = 0; c < N_CL; c++) m[c] = op_at(a, c) != 0;
    return m;
  endfunction

  // L1 memory with a fixed one-cycle read latency
  always_ff @(posedge clk) l1_rdata <= word_at(int'(l1_addr));

  // behavioural reference: 0 idle, 1 fill, 2 execute
  int m_state = 0, m_start = 0, m_ofs = 0, m_fc = 0, m_fend = 0, m_pc = 0;
  bit m_abort = 0, m_dv = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_fill(int st, int of);
    int cnt[N_CL];
    m_state = 1; m_start = st; m_ofs = of; m_fc = 0;
    m_abort = 0; m_fend = of + 1;
    for (int c = 0; c < N_CL; c++) cnt[c] = 0;
    for (int r = 0; r <= of && !m_abort; r++)
      for (int c = 0; c < N_CL; c++)
        if (op_at(st + r, c) != 0) begin
          cnt[c]++;
          if (cnt[c] > PD && !m_abort) begin m_abort = 1; m_fend = r + 1; end
        end
  endtask

  task automatic model_step(bit lb, int st, int of, bit fe, int pc);
    bit dv_n = 0;
    int rel;
    case (m_state)
      0: if (lb && of < TD) start_fill(st, of);
      1: if (m_fc == m_fend) m_state = m_abort ? 0 : 2; else m_fc++;
      default: begin
        if (lb && of < TD) start_fill(st, of);
        else if (fe) begin
          rel = (pc - m_start) & 16'hFFFF;
          if (rel <= m_ofs) begin dv_n = 1; m_pc = pc; end
          else m_state = 0;
        end
      end
    endcase
    m_dv = dv_n;
  endtask

  task automatic compare();
    bit exp_rd = (m_state == 1) && (m_fc <= m_ofs);
    chk("R1 fill_busy", fill_busy, m_state == 1);
    chk("R3 l1_rd", l1_rd, exp_rd);
    if (exp_rd) chk("R3 l1_addr", l1_addr, (m_start + m_fc) & 16'hFFFF);
    chk("R5 dp_valid", dp_valid, m_dv);
    if (m_dv) begin
      chk("R4 dp_ops", dp_ops, word_at(m_pc));
      chk("R6 part_act", part_act, act_at(m_pc));
    end else begin
      chk("R6 part_act idle", part_act, 0);
    end
  endtask

  task automatic cyc(bit lb, int st, int of, bit fe, int pc);
    @(negedge clk);
    compare();
    lbon_valid = lb; lbon_start = AW'(st); lbon_ofs = AW'(of);
    fetch_en = fe; fetch_pc = AW'(pc);
    model_step(lb, st, of, fe, pc);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic wait_fill();
    while (m_state == 1) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic run(int first, int last);
    for (int a = first; a <= last; a++) cyc(0, 0, 0, 1, a);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    chk("R11 fill_busy", fill_busy, 0);
    chk("R11 dp_valid", dp_valid, 0);
    chk("R11 l1_rd", l1_rd, 0);
    chk("R11 part_act", part_act, 0);
    rst = 0;

    idle(2);
    cyc(0, 0, 0, 1, 'h40);          // idle fetch: not served
    cyc(1, 'h40, TD, 0, 0);         // R2: oversize body ignored
    idle(3);

    // R4: every cluster exactly PD operations over 0x40..0x4B
    cyc(1, 'h40, 11, 0, 0);
    cyc(1, 'h10, 2, 0, 0);          // R1: loop start during fill ignored
    wait_fill();
    run('h40, 'h4B);
    run('h40, 'h44);
    run('h48, 'h4B);                // R9: forward jump over a block
    cyc(0, 0, 0, 0, 0);
    run('h40, 'h43);                // R9: back to the loop head
    cyc(0, 0, 0, 1, 'h80);          // R7: exit above the end
    cyc(0, 0, 0, 1, 'h42);          // R7: no service after exit
    idle(2);

    // R8: cluster overflow over 0x100..0x10F abandons the fill
    cyc(1, 'h100, 15, 0, 0);
    wait_fill();
    cyc(0, 0, 0, 1, 'h100);
    cyc(0, 0, 0, 1, 'h103);
    idle(2);

    // loop C then R10: loop start beats a same-cycle fetch
    cyc(1, 'h20, 5, 0, 0);
    wait_fill();
    run('h20, 'h25);
    cyc(1, 'h30, 3, 1, 'h22);
    wait_fill();
    run('h30, 'h33);
    cyc(1, 'h50, TD + 4, 1, 'h31);  // R2: oversize ignored, fetch served
    run('h32, 'h33);
    cyc(0, 0, 0, 1, 'h2F);          // R7: exit below the start
    cyc(0, 0, 0, 1, 'h30);
    // R7 + R1: exit and new loop start in the same cycle
    cyc(1, 'h60, 2, 0, 0);
    wait_fill();
    cyc(1, 'h70, 1, 1, 'hFF);
    wait_fill();
    run('h70, 'h71);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule